// File: doc/BRIEF.md
# SPI FIFO Watermark and Request Controller

This block sits between a simple register bus and an SPI shift engine. It holds a transmit FIFO that software or a DMA engine fills and the shift engine drains, and a receive FIFO that the shift engine fills and software or DMA drains. From the fill levels of the two FIFOs it derives three DMA request lines (transmit, receive, and a receive-tail request for the leftover words below a burst) and one level-sensitive interrupt line.

Software programs a transmit watermark, a receive watermark and a receive-tail watermark, each with its own request enable. The receive watermark field holds the programmed burst size minus one. Software can also drain the receive FIFO by polling: it reads the receive data word for as long as the receive-ready status bit stays set. Incoming engine words reach the receive FIFO only after the receive path has been enabled through the status word.

Top module: `spi_fifo_reqctl`

## Requirements
- R1: After a synchronous active-low reset both FIFOs are empty, the interrupt-enable and DMA control words read zero, the receive path is disabled, all request outputs and the interrupt are low, and the status word (address 4) reads 0x1.
- R2: A bus write to address 0 pushes the 32-bit word into the transmit FIFO, which holds 64 words; the engine sees them oldest first on its data output; a write while 64 words are held is dropped.
- R3: A bus read of address 1 returns the oldest receive word and removes it; a read of an empty receive FIFO returns zero and leaves the FIFO unchanged.
- R4: While status bit 8 is clear, engine receive pushes are discarded; writing address 4 sets the receive enable from bit 8, and bit 8 reads back its value.
- R5: The status word reports transmit-empty on bit 0, transmit-full on bit 1 and receive-ready (receive FIFO not empty) on bit 3; a receive word arriving while 64 words are held is dropped.
- R6: The transmit DMA request is high exactly when DMA control bit 7 is set and the transmit level is at or below bits 5:0.
- R7: The receive DMA request is high exactly when DMA control bit 23 is set and the receive level is greater than bits 21:16 (the burst size minus one).
- R8: The receive-tail DMA request is high exactly when DMA control bit 31 is set, the receive FIFO is not empty, and its level is at or below bits 29:24.
- R9: The interrupt is high exactly when (interrupt-enable bit 0 and transmit FIFO empty) or (interrupt-enable bit 3 and receive FIFO not empty).
- R10: Reading address 2 returns only bits 0 and 3 of the last write; reading address 3 returns the last write masked by 0xBFBF00BF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on receive data address) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | 32 | Head transmit word, zero when empty |
| eng_tx_valid | output | 1 | Transmit FIFO not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| irq | output | 1 | Interrupt request |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_rxtail_req | output | 1 | Receive-tail DMA request |

## Verification
The hardest conditions to reach are the exact level-against-watermark boundaries at both ends of each FIFO, including the full level of 64 that a 6-bit field cannot express. The bench fills each FIFO one word at a time from empty to full and, at every level, sweeps every watermark value through the DMA control word, comparing all three requests against arithmetic computed in the bench. A 65th word is then offered to each full FIFO and the drain order afterwards shows that it was dropped.

// File: rtl/spi_fq_pkg.sv
// Package: shared address map and field positions of the FIFO request controller.
// Assumes a word-addressed register bus with a 3-bit address.
package spi_fq_pkg;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] A_TXDATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_RXDATA = 3'd1;
    localparam logic [ADDR_W-1:0] A_INTEN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DMACTL = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

    // Interrupt-enable bits
    localparam int IE_TXEMPTY = 0;
    localparam int IE_RXRDY   = 3;

    // Status bits
    localparam int ST_TXEMPTY = 0;
    localparam int ST_TXFULL  = 1;
    localparam int ST_RXRDY   = 3;
    localparam int ST_RXEN    = 8;

    // DMA control fields
    localparam int DC_TXWM_LSB   = 0;
    localparam int DC_TXEN       = 7;
    localparam int DC_RXWM_LSB   = 16;
    localparam int DC_RXEN       = 23;
    localparam int DC_TAILWM_LSB = 24;
    localparam int DC_TAILEN     = 31;
endpackage

// File: rtl/spi_fq_fifo.sv
// Module: synchronous FIFO with an occupancy count.
// Pushes while full and pops while empty are ignored; the head word reads
// zero when empty. Storage has no reset; only pointers and count do.
module spi_fq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    // Storage write on an accepted push
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/spi_fq_regs.sv
// Module: configuration registers and read-data multiplexer.
// Holds interrupt enables, DMA watermarks with their enables, and the
// receive enable. Assumes watermark fields are WM_W bits wide.
module spi_fq_regs
    import spi_fq_pkg::*;
#(
    parameter int WM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rx_head,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rdata,
    output logic              ie_tx,
    output logic              ie_rx,
    output logic [WM_W-1:0]   tx_wm,
    output logic [WM_W-1:0]   rx_wm_m1,
    output logic [WM_W-1:0]   tail_wm,
    output logic              tx_den,
    output logic              rx_den,
    output logic              tail_den,
    output logic              rx_en
);
    logic [DATA_W-1:0] ie_word, dc_word, st_word;

    // Register write decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_tx    <= 1'b0;
            ie_rx    <= 1'b0;
            tx_wm    <= '0;
            rx_wm_m1 <= '0;
            tail_wm  <= '0;
            tx_den   <= 1'b0;
            rx_den   <= 1'b0;
            tail_den <= 1'b0;
            rx_en    <= 1'b0;
        end else if (wr) begin
            case (addr)
                A_INTEN: begin
                    ie_tx <= wdata[IE_TXEMPTY];
                    ie_rx <= wdata[IE_RXRDY];
                end
                A_DMACTL: begin
                    tx_wm    <= wdata[DC_TXWM_LSB   +: WM_W];
                    rx_wm_m1 <= wdata[DC_RXWM_LSB   +: WM_W];
                    tail_wm  <= wdata[DC_TAILWM_LSB +: WM_W];
                    tx_den   <= wdata[DC_TXEN];
                    rx_den   <= wdata[DC_RXEN];
                    tail_den <= wdata[DC_TAILEN];
                end
                A_STATUS: rx_en <= wdata[ST_RXEN];
                default: ;
            endcase
        end
    end

    // Assemble read-back words
    always_comb begin
        ie_word = '0;
        ie_word[IE_TXEMPTY] = ie_tx;
        ie_word[IE_RXRDY]   = ie_rx;
        dc_word = '0;
        dc_word[DC_TXWM_LSB   +: WM_W] = tx_wm;
        dc_word[DC_RXWM_LSB   +: WM_W] = rx_wm_m1;
        dc_word[DC_TAILWM_LSB +: WM_W] = tail_wm;
        dc_word[DC_TXEN]   = tx_den;
        dc_word[DC_RXEN]   = rx_den;
        dc_word[DC_TAILEN] = tail_den;
        st_word = '0;
        st_word[ST_TXEMPTY] = tx_empty;
        st_word[ST_TXFULL]  = tx_full;
        st_word[ST_RXRDY]   = rx_ready;
        st_word[ST_RXEN]    = rx_en;
    end

    // Read-data multiplexer
    always_comb begin
        case (addr)
            A_RXDATA: rdata = rx_head;
            A_INTEN:  rdata = ie_word;
            A_DMACTL: rdata = dc_word;
            A_STATUS: rdata = st_word;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_fq_req.sv
// Module: level comparators producing DMA requests and the interrupt.
// Assumes levels are one bit wider than the watermark fields so a full
// FIFO compares correctly.
module spi_fq_req #(
    parameter int LVL_W = 7,
    parameter int WM_W  = 6
) (
    input  logic [LVL_W-1:0] tx_lvl,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic [WM_W-1:0]  tx_wm,
    input  logic [WM_W-1:0]  rx_wm_m1,
    input  logic [WM_W-1:0]  tail_wm,
    input  logic             tx_den,
    input  logic             rx_den,
    input  logic             tail_den,
    input  logic             ie_tx,
    input  logic             ie_rx,
    output logic             dma_tx_req,
    output logic             dma_rx_req,
    output logic             dma_tail_req,
    output logic             irq
);
    logic tx_empty, rx_ready;

    // Watermark compares and interrupt combination
    always_comb begin
        tx_empty     = (tx_lvl == '0);
        rx_ready     = (rx_lvl != '0);
        dma_tx_req   = tx_den && (tx_lvl <= LVL_W'(tx_wm));
        dma_rx_req   = rx_den && (rx_lvl >  LVL_W'(rx_wm_m1));
        dma_tail_req = tail_den && rx_ready && (rx_lvl <= LVL_W'(tail_wm));
        irq          = (ie_tx && tx_empty) || (ie_rx && rx_ready);
    end
endmodule

// File: rtl/spi_fifo_reqctl.sv
// Module: top of the SPI FIFO watermark and request controller.
// Connects the register bus and the shift engine to two FIFOs and derives
// DMA requests and the interrupt from their levels. Reads of the receive
// data address pop in the same cycle; read data is combinational.
module spi_fifo_reqctl
    import spi_fq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int WM_W  = $clog2(DEPTH),
    localparam int LVL_W = WM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_valid,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              irq,
    output logic              dma_tx_req,
    output logic              dma_rx_req,
    output logic              dma_rxtail_req
);
    logic [LVL_W-1:0]  tx_lvl, rx_lvl;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [DATA_W-1:0] rx_head;
    logic              ie_tx, ie_rx, tx_den, rx_den, tail_den, rx_en;
    logic [WM_W-1:0]   tx_wm, rx_wm_m1, tail_wm;
    logic              tx_push, rx_pop, rx_push;

    assign tx_push      = bus_wr && (bus_addr == A_TXDATA);
    assign rx_pop       = bus_rd && (bus_addr == A_RXDATA);
    assign rx_push      = eng_rx_push && rx_en;
    assign eng_tx_valid = !tx_empty;

    spi_fq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(bus_wdata),
        .pop(eng_tx_pop), .head(eng_tx_data),
        .level(tx_lvl), .empty(tx_empty), .full(tx_full)
    );

    spi_fq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(eng_rx_data),
        .pop(rx_pop), .head(rx_head),
        .level(rx_lvl), .empty(rx_empty), .full(rx_full)
    );

    spi_fq_regs #(.WM_W(WM_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .rx_head(rx_head), .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_ready(!rx_empty), .rdata(bus_rdata),
        .ie_tx(ie_tx), .ie_rx(ie_rx),
        .tx_wm(tx_wm), .rx_wm_m1(rx_wm_m1), .tail_wm(tail_wm),
        .tx_den(tx_den), .rx_den(rx_den), .tail_den(tail_den),
        .rx_en(rx_en)
    );

    spi_fq_req #(.LVL_W(LVL_W), .WM_W(WM_W)) u_req (
        .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .tx_wm(tx_wm), .rx_wm_m1(rx_wm_m1), .tail_wm(tail_wm),
        .tx_den(tx_den), .rx_den(rx_den), .tail_den(tail_den),
        .ie_tx(ie_tx), .ie_rx(ie_rx),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
        .dma_tail_req(dma_rxtail_req), .irq(irq)
    );
endmodule

// File: rtl/spi_fifo_reqctl_chk.sv
// Module: property checker for the FIFO request controller, bound to the top.
// Observes ports and the internal FIFO levels and receive enable.
module spi_fifo_reqctl_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7,
    parameter int WM_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [2:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             eng_tx_pop,
    input logic             eng_rx_push,
    input logic [LVL_W-1:0] tx_lvl,
    input logic [LVL_W-1:0] rx_lvl,
    input logic             rx_en,
    input logic [WM_W-1:0]  tx_wm,
    input logic             irq,
    input logic             dma_tx_req
);
    // R2: a write to a full transmit FIFO without an engine pop changes nothing
    p_tx_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl == LVL_W'(DEPTH) && bus_wr && bus_addr == 3'd0 && !eng_tx_pop)
        |=> $stable(tx_lvl));

    // R2: the transmit level never exceeds the depth
    p_tx_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lvl <= LVL_W'(DEPTH));

    // R3: reading an empty receive FIFO returns zero
    p_rx_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lvl == '0 && bus_rd && bus_addr == 3'd1) |-> bus_rdata == '0);

    // R3: an empty read with no engine push leaves the FIFO empty
    p_rx_empty_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lvl == '0 && bus_rd && bus_addr == 3'd1 && !eng_rx_push)
        |=> rx_lvl == '0);

    // R4: with the receive path disabled the level cannot rise
    p_rx_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && eng_rx_push) |=> rx_lvl <= $past(rx_lvl));

    // R6: a transmit request implies the level is within the watermark
    p_txreq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_req |-> tx_lvl <= LVL_W'(tx_wm));

    // R9: the interrupt needs an empty transmit or non-empty receive FIFO
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tx_lvl == '0 || rx_lvl != '0));
endmodule

bind spi_fifo_reqctl spi_fifo_reqctl_chk #(
    .DEPTH(DEPTH), .LVL_W(LVL_W), .WM_W(WM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .rx_en(rx_en), .tx_wm(tx_wm),
    .irq(irq), .dma_tx_req(dma_tx_req)
);

// File: tb/spi_fifo_reqctl_tb.sv
module spi_fifo_reqctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_tx_pop = 1'b0;
    logic [31:0] eng_tx_data;
    logic        eng_tx_valid;
    logic        eng_rx_push = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic        irq, dma_tx_req, dma_rx_req, dma_rxtail_req;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_fifo_reqctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_tx_valid(eng_tx_valid), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .irq(irq), .dma_tx_req(dma_tx_req),
        .dma_rx_req(dma_rx_req), .dma_rxtail_req(dma_rxtail_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Drive a one-cycle write; state is updated when the task returns.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Drive a one-cycle read; data sampled before the edge.
    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rx_push(input logic [31:0] d);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic tx_pop(output logic [31:0] d, output logic v);
        @(negedge clk);
        d = eng_tx_data; v = eng_tx_valid;
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic v;
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 requests", {29'b0, dma_tx_req, dma_rx_req, dma_rxtail_req}, 32'h0);
        check("R1 tx valid", {31'b0, eng_tx_valid}, 32'h0);
        rd(3'd4, d); check("R1 status", d, 32'h1);
        rd(3'd3, d); check("R1 dmactl", d, 32'h0);
        rd(3'd2, d); check("R1 inten", d, 32'h0);

        // R10: read-back masks
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); check("R10 dmactl mask", d, 32'hBFBF_00BF);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d); check("R10 inten mask", d, 32'h9);
        wr(3'd3, 32'h0); wr(3'd2, 32'h0);

        // R9: transmit-empty interrupt
        wr(3'd2, 32'h1);
        check("R9 irq tx empty", {31'b0, irq}, 32'h1);

        // R6 / R2: sweep each transmit level against every watermark
        for (int lvl = 0; lvl <= 64; lvl++) begin
            for (int wm = 0; wm < 64; wm++) begin
                wr(3'd3, 32'h80 | wm);
                check("R6 tx req", {31'b0, dma_tx_req}, {31'b0, (lvl <= wm)});
            end
            wr(3'd3, 32'h3F);
            check("R6 tx req disabled", {31'b0, dma_tx_req}, 32'h0);
            check("R9 irq tx level", {31'b0, irq}, {31'b0, (lvl == 0)});
            rd(3'd4, d);
            check("R5 tx status", d & 32'h3, {30'b0, (lvl == 64), (lvl == 0)});
            if (lvl < 64) wr(3'd0, 32'hA000_0000 + lvl);
        end
        wr(3'd0, 32'hDEAD_BEEF);   // R2: dropped, FIFO full
        for (int i = 0; i < 64; i++) begin
            tx_pop(d, v);
            check("R2 tx order", d, 32'hA000_0000 + i);
        end
        check("R2 tx drained, extra dropped", {31'b0, eng_tx_valid}, 32'h0);
        check("R2 tx head zero", eng_tx_data, 32'h0);
        wr(3'd2, 32'h0);

        // R4: receive path disabled discards pushes
        rx_push(32'h1111_1111); rx_push(32'h2222_2222);
        rd(3'd4, d); check("R4 rx not ready", d, 32'h1);
        rd(3'd1, d); check("R4 rx read zero", d, 32'h0);
        wr(3'd4, 32'h100);
        rd(3'd4, d); check("R4 rx enable readback", d, 32'h101);

        // R3: empty read leaves FIFO untouched, then one word round trip
        rd(3'd1, d); check("R3 empty read zero", d, 32'h0);
        rx_push(32'h5A5A_0001);
        rd(3'd1, d); check("R3 single word", d, 32'h5A5A_0001);
        rd(3'd4, d); check("R3 empty after pop", d & 32'h8, 32'h0);

        // R9: receive-ready interrupt
        wr(3'd2, 32'h8);
        check("R9 irq rx empty", {31'b0, irq}, 32'h0);

        // R7 / R8: sweep each receive level against every field value
        for (int lvl = 0; lvl <= 64; lvl++) begin
            for (int f = 0; f < 64; f++) begin
                wr(3'd3, 32'h8080_0000 | (f << 16) | (f << 24));
                check("R7 rx req", {31'b0, dma_rx_req}, {31'b0, (lvl > f)});
                check("R8 tail req", {31'b0, dma_rxtail_req},
                      {31'b0, (lvl != 0 && lvl <= f)});
            end
            check("R9 irq rx level", {31'b0, irq}, {31'b0, (lvl != 0)});
            if (lvl < 64) rx_push(32'hB000_0000 + lvl);
        end
        wr(3'd3, 32'h003F_0000);
        check("R7 rx req disabled", {31'b0, dma_rx_req}, 32'h0);
        rx_push(32'hDEAD_BEEF);   // R5: dropped, FIFO full

        // R3: poll-drain while receive-ready is set
        cnt = 0;
        rd(3'd4, d);
        while (d[3] && cnt < 80) begin
            logic [31:0] w;
            rd(3'd1, w);
            check("R3 rx order", w, 32'hB000_0000 + cnt);
            cnt++;
            rd(3'd4, d);
        end
        check("R5 rx drained count", cnt, 32'd64);
        rd(3'd1, d); check("R3 read after drain", d, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule